// File: doc/BRIEF.md
# Parallel ADC Host Interface Controller

This block sits on the host side of a 12-bit successive-approximation converter that has a parallel data bus. When the host requests a conversion, the block pulls the conversion-start line low for a fixed number of cycles and then releases it. The release gives the rising edge that a converter coming out of an automatic power-down needs. The block then waits for the converter's busy flag to go high and come back low. After that it reads the result with active-low chip-select and read strobes.

A static width-select input sets how the bus is used. In word mode, one access carries all twelve bits. In byte mode, only the lower eight lines carry data, and a separate high-byte-enable output picks which half the access transfers. The high half also carries the 2-bit channel tag of the result. The block rebuilds the sample, extracts the tag and presents both with a one-cycle valid strobe. It can also write a 12-bit control word. In byte mode it splits the word into a low access and a high access, and the high access has its upper nibble forced to zero. If busy does not complete within a programmable number of cycles, the block pulses an error flag and returns to idle.

Top module: `adc_par_host`

## Requirements
- R1: While reset is held and directly after it: adc_convst_no, adc_cs_no, adc_rd_no and adc_wr_no are 1; valid_o, err_o and adc_db_oe_o are 0; ready_o is 1.
- R2: A conv_req_i seen while ready_o is 1 drives adc_convst_no low for exactly CONV_LOW cycles and then returns it high. If conv_req_i and cfg_req_i arrive in the same cycle, the conversion is served and the write is dropped.
- R3: Once a conversion has started, the result is read only after adc_busy_i has been seen high and then low. If that has not happened within timeout_i cycles, err_o pulses for one cycle, no read access is made, and ready_o returns to 1.
- R4: In word mode (word_mode_i = 1), the result is fetched with one read access. sample_o equals adc_db_i[11:0] and chan_o is 0.
- R5: In byte mode (word_mode_i = 0), the result is fetched with two reads: first with adc_hben_o = 0, then with adc_hben_o = 1. sample_o = {high[3:0], low[7:0]} and chan_o = high[5:4]. High bits 7:6 and adc_db_i[11:8] are ignored.
- R6: Each completed conversion gives exactly one valid_o pulse, one cycle long, after the last read. sample_o and chan_o hold their values until the next valid_o.
- R7: In every access, adc_cs_no stays low for exactly RD_WAIT cycles together with one of adc_rd_no and adc_wr_no. Read data is taken in the last low cycle. The strobes return high for at least one cycle between accesses, and adc_rd_no and adc_wr_no are never low together.
- R8: A word-mode write (cfg_req_i) makes one access with adc_db_o[11:0] = cfg_data_i and adc_db_oe_o = 1 while adc_wr_no is low.
- R9: A byte-mode write makes a low access (adc_hben_o = 0, adc_db_o[7:0] = data[7:0]) and then a high access (adc_hben_o = 1, adc_db_o[3:0] = data[11:8]). Bits 11:4 are 0 in the high access, and bits 11:8 are 0 in the low access.
- R10: No bus access (adc_cs_no low) occurs while adc_convst_no is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| word_mode_i | input | 1 | 1 = word transfers, 0 = byte transfers; latched per transaction |
| conv_req_i | input | 1 | Request a conversion and readout |
| cfg_req_i | input | 1 | Request a control-word write |
| cfg_data_i | input | 12 | Control word to write |
| timeout_i | input | TO_W | Cycle limit for the busy handshake |
| ready_o | output | 1 | Controller idle, requests accepted |
| sample_o | output | 12 | Last converted sample |
| chan_o | output | 2 | Channel tag of the last sample |
| valid_o | output | 1 | One-cycle strobe for a new sample |
| err_o | output | 1 | One-cycle strobe on busy timeout |
| adc_convst_no | output | 1 | Conversion start, falling edge starts |
| adc_cs_no | output | 1 | Chip select, active low |
| adc_rd_no | output | 1 | Read strobe, active low |
| adc_wr_no | output | 1 | Write strobe, active low |
| adc_hben_o | output | 1 | High-byte select in byte mode |
| adc_db_o | output | 12 | Write data toward the converter |
| adc_db_oe_o | output | 1 | Output enable for adc_db_o |
| adc_busy_i | input | 1 | Converter busy flag |
| adc_db_i | input | 12 | Read data from the converter |

## Verification
The checks assume that adc_busy_i rises only after adc_convst_no has fallen, and that word_mode_i changes only while ready_o is 1. The bench's converter model starts busy a few cycles after the start edge and holds it high for a fixed span shorter than the timeout. It can also hold busy high indefinitely to drive the timeout path. Mode changes and new requests are made only between transactions. The model drives valid read data only in the last cycle of the read window and junk on the upper lines in byte mode, so a mistimed capture or a missing mask shows up in the sample.

// File: rtl/adc_host_pkg.sv
package adc_host_pkg;
  localparam int unsigned DATA_W = 12;
  localparam int unsigned CHAN_W = 2;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned NIB_W  = DATA_W - BYTE_W;

  typedef enum logic [3:0] {
    ST_IDLE, ST_CONV, ST_WAIT, ST_RD_LO, ST_RD_HI, ST_RD_WORD,
    ST_DONE, ST_WR_LO, ST_WR_HI, ST_WR_WORD
  } host_st_e;

  typedef enum logic [1:0] {AC_IDLE, AC_ACT, AC_REC} acc_st_e;
endpackage

// File: rtl/adc_bus_access.sv
module adc_bus_access
  import adc_host_pkg::*;
#(
  parameter int unsigned WAIT_CYC = 3,
  parameter int unsigned DW       = DATA_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          is_rd_i,
  input  logic          hben_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] db_i,
  output logic          cs_no,
  output logic          rd_no,
  output logic          wr_no,
  output logic          hben_o,
  output logic [DW-1:0] db_o,
  output logic          db_oe_o,
  output logic [DW-1:0] rdata_o,
  output logic          done_o
);
  localparam int unsigned CNT_W = $clog2(WAIT_CYC + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WAIT_CYC - 1);

  acc_st_e          st_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= AC_IDLE;
      cnt_q   <= '0;
      cs_no   <= 1'b1;
      rd_no   <= 1'b1;
      wr_no   <= 1'b1;
      hben_o  <= 1'b0;
      db_o    <= '0;
      db_oe_o <= 1'b0;
      rdata_o <= '0;
    end else begin
      unique case (st_q)
        AC_IDLE: if (req_i) begin
          st_q    <= AC_ACT;
          cnt_q   <= '0;
          cs_no   <= 1'b0;
          rd_no   <= !is_rd_i;
          wr_no   <= is_rd_i;
          hben_o  <= hben_i;
          db_o    <= is_rd_i ? '0 : wdata_i;
          db_oe_o <= !is_rd_i;
        end
        AC_ACT: begin
          if (cnt_q == LAST) begin
            if (!rd_no) rdata_o <= db_i;
            cs_no <= 1'b1;
            rd_no <= 1'b1;
            wr_no <= 1'b1;
            st_q  <= AC_REC;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: begin
          db_oe_o <= 1'b0;
          db_o    <= '0;
          hben_o  <= 1'b0;
          st_q    <= AC_IDLE;
        end
      endcase
    end
  end

  assign done_o = (st_q == AC_REC);

  // R7
  rd_wr_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!rd_no && !wr_no));
  // R7
  strobe_in_cs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_no || !wr_no) |-> !cs_no);
  // R7
  release_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (cs_no && rd_no && wr_no));
endmodule

// File: rtl/adc_busy_timer.sv
module adc_busy_timer #(
  parameter int unsigned TO_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            run_i,
  input  logic            busy_i,
  input  logic [TO_W-1:0] limit_i,
  output logic            fell_o,
  output logic            expired_o
);
  logic [TO_W-1:0] cnt_q;
  logic            seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      seen_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q  <= '0;
      seen_q <= 1'b0;
    end else begin
      if (cnt_q != '1) cnt_q <= cnt_q + 1'b1;
      if (busy_i) seen_q <= 1'b1;
    end
  end

  assign fell_o    = run_i && seen_q && !busy_i;
  assign expired_o = run_i && (cnt_q >= limit_i);
endmodule

// File: rtl/adc_result_pack.sv
module adc_result_pack
  import adc_host_pkg::*;
(
  input  logic              word_mode_i,
  input  logic [DATA_W-1:0] word_i,
  input  logic [BYTE_W-1:0] lo_i,
  input  logic [NIB_W-1:0]  hi_nib_i,
  input  logic [CHAN_W-1:0] id_i,
  output logic [DATA_W-1:0] sample_o,
  output logic [CHAN_W-1:0] chan_o
);
  always_comb begin
    if (word_mode_i) begin
      sample_o = word_i;
      chan_o   = '0;
    end else begin
      sample_o = {hi_nib_i, lo_i};
      chan_o   = id_i;
    end
  end
endmodule

// File: rtl/adc_par_host.sv
module adc_par_host
  import adc_host_pkg::*;
#(
  parameter int unsigned RD_WAIT  = 3,
  parameter int unsigned CONV_LOW = 2,
  parameter int unsigned TO_W     = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              word_mode_i,
  input  logic              conv_req_i,
  input  logic              cfg_req_i,
  input  logic [DATA_W-1:0] cfg_data_i,
  input  logic [TO_W-1:0]   timeout_i,
  output logic              ready_o,
  output logic [DATA_W-1:0] sample_o,
  output logic [CHAN_W-1:0] chan_o,
  output logic              valid_o,
  output logic              err_o,
  output logic              adc_convst_no,
  output logic              adc_cs_no,
  output logic              adc_rd_no,
  output logic              adc_wr_no,
  output logic              adc_hben_o,
  output logic [DATA_W-1:0] adc_db_o,
  output logic              adc_db_oe_o,
  input  logic              adc_busy_i,
  input  logic [DATA_W-1:0] adc_db_i
);
  localparam int unsigned CV_W = $clog2(CONV_LOW + 1);
  localparam logic [CV_W-1:0] CV_LAST = CV_W'(CONV_LOW - 1);
  localparam int unsigned ID_LO = NIB_W;

  host_st_e          st_q;
  logic [CV_W-1:0]   cv_cnt_q;
  logic              mode_q;
  logic [DATA_W-1:0] cfg_q;
  logic [DATA_W-1:0] word_q;
  logic [BYTE_W-1:0] lo_q;
  logic [NIB_W+CHAN_W-1:0] hi_q;

  logic              acc_req, acc_rd, acc_hben, acc_done;
  logic [DATA_W-1:0] acc_wdata, acc_rdata;
  logic              tmr_fell, tmr_exp, tmr_run;
  logic [DATA_W-1:0] pk_sample;
  logic [CHAN_W-1:0] pk_chan;

  always_comb begin
    acc_req  = 1'b0;
    acc_rd   = 1'b0;
    acc_hben = 1'b0;
    unique case (st_q)
      ST_RD_LO:   begin acc_req = 1'b1; acc_rd = 1'b1; end
      ST_RD_HI:   begin acc_req = 1'b1; acc_rd = 1'b1; acc_hben = 1'b1; end
      ST_RD_WORD: begin acc_req = 1'b1; acc_rd = 1'b1; end
      ST_WR_LO:   acc_req = 1'b1;
      ST_WR_HI:   begin acc_req = 1'b1; acc_hben = 1'b1; end
      ST_WR_WORD: acc_req = 1'b1;
      default:    ;
    endcase
  end

  // high write byte carries only the top nibble; upper bits forced low
  always_comb begin
    unique case (st_q)
      ST_WR_LO: acc_wdata = {{NIB_W{1'b0}}, cfg_q[BYTE_W-1:0]};
      ST_WR_HI: acc_wdata = {{BYTE_W{1'b0}}, cfg_q[DATA_W-1:BYTE_W]};
      default:  acc_wdata = cfg_q;
    endcase
  end

  assign tmr_run = (st_q == ST_CONV) || (st_q == ST_WAIT);

  adc_bus_access #(.WAIT_CYC(RD_WAIT), .DW(DATA_W)) u_acc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (acc_req),
    .is_rd_i (acc_rd),
    .hben_i  (acc_hben),
    .wdata_i (acc_wdata),
    .db_i    (adc_db_i),
    .cs_no   (adc_cs_no),
    .rd_no   (adc_rd_no),
    .wr_no   (adc_wr_no),
    .hben_o  (adc_hben_o),
    .db_o    (adc_db_o),
    .db_oe_o (adc_db_oe_o),
    .rdata_o (acc_rdata),
    .done_o  (acc_done)
  );

  adc_busy_timer #(.TO_W(TO_W)) u_tmr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (tmr_run),
    .busy_i    (adc_busy_i),
    .limit_i   (timeout_i),
    .fell_o    (tmr_fell),
    .expired_o (tmr_exp)
  );

  adc_result_pack u_pack (
    .word_mode_i (mode_q),
    .word_i      (word_q),
    .lo_i        (lo_q),
    .hi_nib_i    (hi_q[NIB_W-1:0]),
    .id_i        (hi_q[ID_LO+CHAN_W-1:ID_LO]),
    .sample_o    (pk_sample),
    .chan_o      (pk_chan)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q          <= ST_IDLE;
      cv_cnt_q      <= '0;
      mode_q        <= 1'b0;
      cfg_q         <= '0;
      word_q        <= '0;
      lo_q          <= '0;
      hi_q          <= '0;
      adc_convst_no <= 1'b1;
      sample_o      <= '0;
      chan_o        <= '0;
      valid_o       <= 1'b0;
      err_o         <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      err_o   <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (conv_req_i) begin
            mode_q        <= word_mode_i;
            cv_cnt_q      <= '0;
            adc_convst_no <= 1'b0;
            st_q          <= ST_CONV;
          end else if (cfg_req_i) begin
            mode_q <= word_mode_i;
            cfg_q  <= cfg_data_i;
            st_q   <= word_mode_i ? ST_WR_WORD : ST_WR_LO;
          end
        end
        ST_CONV: begin
          if (tmr_exp) begin
            adc_convst_no <= 1'b1;
            err_o         <= 1'b1;
            st_q          <= ST_IDLE;
          end else if (cv_cnt_q == CV_LAST) begin
            adc_convst_no <= 1'b1;
            st_q          <= ST_WAIT;
          end else begin
            cv_cnt_q <= cv_cnt_q + 1'b1;
          end
        end
        ST_WAIT: begin
          if (tmr_fell) begin
            st_q <= mode_q ? ST_RD_WORD : ST_RD_LO;
          end else if (tmr_exp) begin
            err_o <= 1'b1;
            st_q  <= ST_IDLE;
          end
        end
        ST_RD_LO: if (acc_done) begin
          lo_q <= acc_rdata[BYTE_W-1:0];
          st_q <= ST_RD_HI;
        end
        ST_RD_HI: if (acc_done) begin
          hi_q <= acc_rdata[NIB_W+CHAN_W-1:0];
          st_q <= ST_DONE;
        end
        ST_RD_WORD: if (acc_done) begin
          word_q <= acc_rdata;
          st_q   <= ST_DONE;
        end
        ST_DONE: begin
          sample_o <= pk_sample;
          chan_o   <= pk_chan;
          valid_o  <= 1'b1;
          st_q     <= ST_IDLE;
        end
        ST_WR_LO:   if (acc_done) st_q <= ST_WR_HI;
        ST_WR_HI:   if (acc_done) st_q <= ST_IDLE;
        ST_WR_WORD: if (acc_done) st_q <= ST_IDLE;
        default:    st_q <= ST_IDLE;
      endcase
    end
  end

  assign ready_o = (st_q == ST_IDLE);

  // R10
  conv_no_access_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adc_convst_no |-> adc_cs_no);
  // R9
  hi_write_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adc_wr_no && adc_hben_o) |-> (adc_db_o[DATA_W-1:NIB_W] == '0));
  // R8
  write_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adc_wr_no |-> adc_db_oe_o);
  // R3
  err_to_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (ready_o && !valid_o && adc_convst_no));
  // R6
  valid_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
  // R6
  valid_bus_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (adc_cs_no && ready_o));
endmodule

// File: tb/adc_par_host_tb_top.sv
module adc_par_host_tb_top;
  localparam int unsigned RD_WAIT  = 3;
  localparam int unsigned CONV_LOW = 2;
  localparam int unsigned TO_W     = 8;
  localparam int BZ_START = 3;
  localparam int BZ_END   = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        word_mode = 1'b1;
  logic        conv_req = 1'b0;
  logic        cfg_req = 1'b0;
  logic [11:0] cfg_data = '0;
  logic [TO_W-1:0] timeout = 8'd40;
  logic        ready, valid, err;
  logic [11:0] sample;
  logic [1:0]  chan;
  logic        convst_n, cs_n, rd_n, wr_n, hben, db_oe;
  logic [11:0] db_o, db_i;
  logic        busy;

  adc_par_host #(.RD_WAIT(RD_WAIT), .CONV_LOW(CONV_LOW), .TO_W(TO_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .word_mode_i(word_mode),
    .conv_req_i(conv_req), .cfg_req_i(cfg_req), .cfg_data_i(cfg_data),
    .timeout_i(timeout), .ready_o(ready), .sample_o(sample), .chan_o(chan),
    .valid_o(valid), .err_o(err), .adc_convst_no(convst_n), .adc_cs_no(cs_n),
    .adc_rd_no(rd_n), .adc_wr_no(wr_n), .adc_hben_o(hben), .adc_db_o(db_o),
    .adc_db_oe_o(db_oe), .adc_busy_i(busy), .adc_db_i(db_i)
  );

  // converter model
  logic [11:0] m_sample = '0;
  logic [1:0]  m_chan = '0;
  logic        m_stuck = 1'b0;
  int          phase = 0;
  logic        cv_prev = 1'b1;
  int          rd_run = 0, wr_run = 0, cv_run = 0;
  logic        cs_prev = 1'b1;
  logic        v_prev = 1'b0;
  int          valid_cnt = 0, err_cnt = 0, cs_falls = 0, rd_bad = 0, wr_bad = 0;
  int          cv_bad = 0, overlap = 0, oe_bad = 0, vwide = 0, cv_falls = 0;
  logic [11:0] cap_word = '0, cap_lo = '0, cap_hi = '0;

  assign busy = (phase >= BZ_START);

  always_comb begin
    if (!cs_n && !rd_n && rd_run == RD_WAIT - 1) begin
      if (word_mode)  db_i = m_sample;
      else if (hben)  db_i = {4'hA, 2'b00, m_chan, m_sample[11:8]};
      else            db_i = {4'hA, m_sample[7:0]};
    end else begin
      db_i = 12'h5A5;
    end
  end

  always @(posedge clk) begin
    cv_prev <= convst_n;
    if (cv_prev && !convst_n) begin
      phase    <= 1;
      cv_falls <= cv_falls + 1;
    end else if (phase > 0 && phase < BZ_END) phase <= phase + 1;
    else if (phase == BZ_END && !m_stuck) phase <= 0;

    rd_run <= !rd_n ? rd_run + 1 : 0;
    if (rd_n && rd_run != 0 && rd_run != RD_WAIT) rd_bad <= rd_bad + 1;
    wr_run <= !wr_n ? wr_run + 1 : 0;
    if (wr_n && wr_run != 0 && wr_run != RD_WAIT) wr_bad <= wr_bad + 1;
    cv_run <= !convst_n ? cv_run + 1 : 0;
    if (convst_n && cv_run != 0 && cv_run != CONV_LOW) cv_bad <= cv_bad + 1;

    cs_prev <= cs_n;
    if (cs_prev && !cs_n) cs_falls <= cs_falls + 1;
    if (!convst_n && !cs_n) overlap <= overlap + 1;
    v_prev <= valid;
    if (valid) valid_cnt <= valid_cnt + 1;
    if (valid && v_prev) vwide <= vwide + 1;
    if (err) err_cnt <= err_cnt + 1;
    if (!cs_n && !wr_n) begin
      if (!db_oe) oe_bad <= oe_bad + 1;
      if (word_mode) cap_word <= db_o;
      else if (hben) cap_hi <= db_o;
      else cap_lo <= db_o;
    end
  end

  int checks = 0, errors = 0;
  logic wd_fired = 1'b0;

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_ready();
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (ready) return;
    end
    chk(1'b0, "R3 hang", 0, 1);
  endtask

  task automatic run_conv(input logic mode, input logic [11:0] s, input logic [1:0] c,
                          input logic stuck);
    int v0, e0, f0, rb0, ov0, cb0, cvf0;
    word_mode = mode; m_sample = s; m_chan = c; m_stuck = stuck;
    @(negedge clk);
    v0 = valid_cnt; e0 = err_cnt; f0 = cs_falls; rb0 = rd_bad; ov0 = overlap;
    cb0 = cv_bad; cvf0 = cv_falls;
    conv_req = 1'b1;
    @(negedge clk);
    conv_req = 1'b0;
    wait_ready();
    repeat (3) @(negedge clk);
    if (stuck) begin
      chk(err_cnt == e0 + 1, "R3 timeout err", err_cnt - e0, 1);
      chk(valid_cnt == v0, "R3 no valid on timeout", valid_cnt - v0, 0);
      chk(cs_falls == f0, "R3 no read on timeout", cs_falls - f0, 0);
      m_stuck = 1'b0;
      repeat (4) @(negedge clk);
    end else begin
      chk(sample == s, mode ? "R4 sample" : "R5 sample", sample, s);
      chk(chan == (mode ? 2'd0 : c), mode ? "R4 chan" : "R5 chan", chan, mode ? 0 : c);
      chk(valid_cnt == v0 + 1, "R6 one valid", valid_cnt - v0, 1);
      chk(cs_falls == f0 + (mode ? 1 : 2), mode ? "R4 accesses" : "R5 accesses",
          cs_falls - f0, mode ? 1 : 2);
      chk(err_cnt == e0, "R3 no err", err_cnt - e0, 0);
    end
    chk(rd_bad == rb0, "R7 read width", rd_bad - rb0, 0);
    chk(overlap == ov0, "R10 access during start", overlap - ov0, 0);
    chk(cv_bad == cb0 && cv_falls == cvf0 + 1, "R2 start pulse", cv_falls - cvf0, 1);
  endtask

  task automatic run_cfg(input logic mode, input logic [11:0] d);
    int f0, wb0, ob0;
    word_mode = mode;
    @(negedge clk);
    f0 = cs_falls; wb0 = wr_bad; ob0 = oe_bad;
    cfg_data = d; cfg_req = 1'b1;
    @(negedge clk);
    cfg_req = 1'b0;
    wait_ready();
    repeat (2) @(negedge clk);
    if (mode) begin
      chk(cap_word == d, "R8 word write", cap_word, d);
      chk(cs_falls == f0 + 1, "R8 one access", cs_falls - f0, 1);
    end else begin
      chk(cap_lo == {4'h0, d[7:0]}, "R9 low byte", cap_lo, {4'h0, d[7:0]});
      chk(cap_hi == {8'h00, d[11:8]}, "R9 high byte", cap_hi, {8'h00, d[11:8]});
      chk(cs_falls == f0 + 2, "R9 two accesses", cs_falls - f0, 2);
    end
    chk(wr_bad == wb0, "R7 write width", wr_bad - wb0, 0);
    chk(oe_bad == ob0, "R8 drive enable", oe_bad - ob0, 0);
  endtask

  initial begin
    for (int i = 0; i < 150000; i++) @(posedge clk);
    wd_fired = 1'b1;
    errors++;
    checks++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk(convst_n && cs_n && rd_n && wr_n, "R1 strobes in reset", {convst_n, cs_n, rd_n, wr_n}, 4'hF);
    chk(!valid && !err && !db_oe && ready, "R1 status in reset", {valid, err, db_oe, ready}, 4'h1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(convst_n && cs_n && ready && !valid, "R1 after reset", {convst_n, cs_n, ready, valid}, 4'hE);

    for (int m = 0; m < 2; m++) begin
      run_conv(m[0], 12'h000, 2'd0, 1'b0);
      run_conv(m[0], 12'hFFF, 2'd3, 1'b0);
      for (int k = 0; k < 40; k++)
        run_conv(m[0], 12'((k * 1103 + 7) % 4096), 2'(k % 4), 1'b0);
      for (int k = 0; k < 16; k++)
        run_conv(m[0], 12'(1 << (k % 12)) ^ 12'(k * 17), 2'(k), 1'b0);
    end

    for (int m = 0; m < 2; m++) begin
      run_cfg(m[0], 12'hFFF);
      run_cfg(m[0], 12'h000);
      for (int k = 0; k < 16; k++) run_cfg(m[0], 12'((k * 2731 + 5) % 4096));
    end

    // R3 timeout in both modes, then recovery
    run_conv(1'b0, 12'h123, 2'd1, 1'b1);
    run_conv(1'b0, 12'h9C4, 2'd2, 1'b0);
    run_conv(1'b1, 12'h456, 2'd0, 1'b1);
    run_conv(1'b1, 12'hB0D, 2'd0, 1'b0);

    // R2 simultaneous requests: conversion wins, write dropped
    begin
      logic [11:0] w0;
      word_mode = 1'b1; m_sample = 12'h3E7; m_chan = 2'd2;
      w0 = cap_word;
      @(negedge clk);
      cfg_data = ~w0; cfg_req = 1'b1; conv_req = 1'b1;
      @(negedge clk);
      cfg_req = 1'b0; conv_req = 1'b0;
      wait_ready();
      repeat (3) @(negedge clk);
      chk(sample == 12'h3E7, "R2 priority sample", sample, 12'h3E7);
      chk(cap_word == w0, "R2 write dropped", cap_word, w0);
    end

    // R6 sample holds between valids
    repeat (20) @(negedge clk);
    chk(sample == 12'h3E7 && vwide == 0, "R6 hold and width", sample, 12'h3E7);

    if (!wd_fired) begin
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule